// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs Clause 22 management transactions to an external PHY over the two-wire MDC/MDIO bus. Software controls it through one 32-bit command/status word. It writes the operation, PHY address, register address and, for a write, the data into that word with the start bit set. The engine then produces MDC from the system clock and shifts out the complete frame. It clears the start bit, which also serves as the busy flag, once the frame ends.

For a read, the engine lets go of MDIO for the turnaround and the data phase and samples the PHY's sixteen bits. Those bits replace the low half of the same command word. If the PHY does not pull the second turnaround bit low, a failure flag is raised. Software polls the busy flag with a timeout of a few milliseconds. A transaction lasts 128 half-periods of MDC, which keeps it far inside that window.

Top module: `mdio_cmd_engine`

## Requirements
- R1: A write of the command word with bit 29 set while bit 29 reads 0 starts a transaction. Bit 29 reads 1 from the next cycle and returns to 0 when the frame completes.
- R2: A write of the command word while bit 29 reads 1 has no effect. Fields 27:16 keep their value, no second frame is sent, and the frame in flight is unchanged.
- R3: The frame is sent on MDIO MSB first, in this order: 32 ones, start bits 0 then 1, opcode (bits 27:26), PHY address (bits 25:21), register address (bits 20:16), turnaround, and 16 data bits (bits 15:0). When the opcode is not 2'b10, the turnaround is driven as 1 then 0.
- R4: Opcode 2'b10 selects a read. The engine stops driving MDIO (mdio_oe low) from the first turnaround bit to the end of the frame. The 16 bits it samples, MSB first, replace bits 15:0 when the frame completes.
- R5: Bit 28 reads 1 after a read in which MDIO was sampled high during the second turnaround bit. A read that samples it low leaves bit 28 at 0, and every new start clears bit 28.
- R6: MDC stays low while bit 29 reads 0. While busy, MDC toggles every HALF_DIV system cycles, and mdio_o and mdio_oe never change on a rising edge of MDC.
- R7: Bit 29 stays at 1 for exactly 128*HALF_DIV system cycles after the starting write.
- R8: A write with bit 29 clear while idle stores fields 27:0 for readback. It sends no frame, and bit 28 keeps its value.
- R9: After reset, and after a reset that arrives during a frame, the command word reads 0, MDC is low and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Value written to the command word |
| cmd_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable, high while the engine drives |
| mdio_i | input | 1 | MDIO as seen on the bus (pulled high when nobody drives) |

## Verification
The checker takes for granted that cmd_we is a single-cycle strobe sampled at the rising clock edge. It also assumes that HALF_DIV is at least 2, so the engine's MDIO update and the MDC rise never fall in the same cycle. The bench drives every write at the falling clock edge for exactly one cycle. Its PHY model answers only on the falling edge of MDC during the slots the engine has released, so the bus is never driven from both sides. For a failed read, the PHY model drives nothing and the bus idles high.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

    localparam int CMD_W      = 32;
    localparam int BUSY_BIT   = 29;
    localparam int FAIL_BIT   = 28;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + ADDR_W + ADDR_W + 2 + DATA_W;
    localparam int TA_SLOT    = FRAME_BITS - DATA_W - 2;
    localparam int DATA_SLOT  = FRAME_BITS - DATA_W;
    localparam int SLOT_W     = $clog2(FRAME_BITS);

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic [1:0]        op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    function automatic mdio_cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
        return mdio_cmd_t'(w[$bits(mdio_cmd_t)-1:0]);
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_of(input mdio_cmd_t c);
        return {{PRE_BITS{1'b1}}, 2'b01, c.op, c.phy, c.regad, 2'b10, c.data};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_serializer.sv
module mdio_serializer
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  mdio_cmd_t         launch_cmd,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fail
);
    localparam slot_t LAST_SLOT = slot_t'(FRAME_BITS - 1);
    localparam slot_t TA1       = slot_t'(TA_SLOT);
    localparam slot_t TA2       = slot_t'(TA_SLOT + 1);
    localparam slot_t D0        = slot_t'(DATA_SLOT);

    logic                  active;
    logic                  is_read;
    logic [FRAME_BITS-1:0] shreg;
    slot_t                 slot;
    logic                  released;

    assign released = is_read && (slot >= TA1);
    assign mdio_oe  = active && !released;
    assign mdio_o   = active ? shreg[FRAME_BITS-1] : 1'b1;
    assign done     = active && fall_tick && (slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            is_read <= 1'b0;
            shreg   <= '0;
            slot    <= '0;
            rd_data <= '0;
            rd_fail <= 1'b0;
        end else if (launch) begin
            active  <= 1'b1;
            is_read <= (launch_cmd.op == OP_READ);
            shreg   <= frame_of(launch_cmd);
            slot    <= '0;
            rd_data <= '0;
            rd_fail <= 1'b0;
        end else if (active) begin
            if (fall_tick) begin
                if (slot == LAST_SLOT) begin
                    active <= 1'b0;
                end else begin
                    slot  <= slot + 1'b1;
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
                end
            end
            if (rise_tick && is_read) begin
                if (slot == TA2 && mdio_i != 1'b0)
                    rd_fail <= 1'b1;
                if (slot >= D0)
                    rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CMD_W-1:0]  wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_fail,
    output logic              launch,
    output mdio_cmd_t         launch_cmd,
    output logic              busy,
    output logic [CMD_W-1:0]  rdata
);
    mdio_cmd_t cmd_q;
    logic      busy_q;
    logic      fail_q;
    logic      accept;
    logic      unused_bits;

    assign unused_bits = ^{wdata[CMD_W-1:BUSY_BIT+1], wdata[FAIL_BIT]};
    assign launch_cmd  = unpack_cmd(wdata);
    assign accept      = we && !busy_q;
    assign launch      = accept && wdata[BUSY_BIT];
    assign busy        = busy_q;
    assign rdata       = {{(CMD_W-BUSY_BIT-1){1'b0}}, busy_q, fail_q, cmd_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            busy_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (accept) begin
            cmd_q  <= launch_cmd;
            busy_q <= wdata[BUSY_BIT];
            if (wdata[BUSY_BIT])
                fail_q <= 1'b0;
        end else if (done) begin
            busy_q <= 1'b0;
            if (cmd_q.op == OP_READ) begin
                cmd_q.data <= rd_data;
                fail_q     <= rd_fail;
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_eng_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              launch;
    mdio_cmd_t         launch_cmd;
    logic              busy;
    logic              rise_tick;
    logic              fall_tick;
    logic              done;
    logic [DATA_W-1:0] rd_data;
    logic              rd_fail;

    mdio_cmd_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .we         (cmd_we),
        .wdata      (cmd_wdata),
        .done       (done),
        .rd_data    (rd_data),
        .rd_fail    (rd_fail),
        .launch     (launch),
        .launch_cmd (launch_cmd),
        .busy       (busy),
        .rdata      (cmd_rdata)
    );

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_cmd (launch_cmd),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (done),
        .rd_data    (rd_data),
        .rd_fail    (rd_fail)
    );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
    parameter int HALF_DIV = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_we,
    input logic [31:0] cmd_wdata,
    input logic [31:0] cmd_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic [31:0] busy_cycles;

    always_ff @(posedge clk) begin
        if (rst || !cmd_rdata[29])
            busy_cycles <= '0;
        else
            busy_cycles <= busy_cycles + 1'b1;
    end

    // R1: an idle write carrying the start bit makes busy visible next cycle
    a_r1_launch: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_rdata[29] && cmd_wdata[29]) |=> cmd_rdata[29]);

    // R2: writes during a transaction leave the command fields alone
    a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_rdata[29]) |=> $stable(cmd_rdata[27:16]));

    // R6: the management clock is parked low while idle
    a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
        !cmd_rdata[29] |-> !mdc);

    // R6: the driven value never moves on a rising MDC edge
    a_r6_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7: busy never outlives the frame length
    a_r7_time_bound: assert property (@(posedge clk) disable iff (rst)
        busy_cycles <= 32'(128 * HALF_DIV));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;

    localparam int HALF = 2;
    localparam int TXN_CYCLES = 128 * HALF;
    localparam int NVEC = 7;
    // {op, phy, reg, data, phy_response, ta_driven}
    localparam logic [44:0] VEC [NVEC] = '{
        {2'd1, 5'd1,  5'd0,  16'h1140, 16'h0000, 1'b1},
        {2'd2, 5'd1,  5'd2,  16'h0000, 16'h600D, 1'b1},
        {2'd1, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b1},
        {2'd2, 5'd0,  5'd1,  16'hABCD, 16'h796D, 1'b1},
        {2'd2, 5'd17, 5'd9,  16'h0000, 16'h1234, 1'b0},
        {2'd2, 5'd5,  5'd3,  16'h0000, 16'h8001, 1'b1},
        {2'd1, 5'd10, 5'd21, 16'h0000, 16'h0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    // PHY model state
    int          rise_n = 0;
    logic [63:0] seen = '0;
    logic        is_rd = 1'b0;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;
    logic [15:0] phy_data = '0;
    logic        phy_ta_ok = 1'b1;
    logic        oe_clash = 1'b0;

    always #10 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    mdio_cmd_engine #(.HALF_DIV(HALF)) uut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge mdc) begin
        seen = {seen[62:0], mdio_i};
        if (is_rd && rise_n >= 46 && mdio_oe) oe_clash = 1'b1;
        rise_n = rise_n + 1;
    end

    always @(negedge mdc) begin
        if (is_rd && rise_n == 47) begin
            phy_en  = phy_ta_ok;
            phy_bit = 1'b0;
        end else if (is_rd && rise_n >= 48 && rise_n <= 63) begin
            phy_en  = phy_ta_ok;
            phy_bit = phy_data[63 - rise_n];
        end else begin
            phy_en  = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic start, input logic [1:0] op,
                                            input logic [4:0] phy, input logic [4:0] rg,
                                            input logic [15:0] d);
        return {2'b00, start, 1'b0, op, phy, rg, d};
    endfunction

    function automatic logic [63:0] frame_exp(input logic [1:0] op, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
    endfunction

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic arm_phy(input logic rd, input logic [15:0] resp, input logic ta_ok);
        is_rd = rd;
        phy_data = resp;
        phy_ta_ok = ta_ok;
        rise_n = 0;
        seen = '0;
        oe_clash = 1'b0;
    endtask

    task automatic run_txn(input logic [31:0] w, output int cyc);
        write_word(w);
        cyc = 0;
        while (cmd_rdata[29] && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(cmd_rdata == 32'h0, "R9 reset word", {32'h0, cmd_rdata}, 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 reset pins", {62'h0, mdc, mdio_oe}, 64'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [4:0]  phy, rg;
            logic [15:0] d, resp, exp_d;
            logic        ta_ok, rd, exp_fail;
            logic [63:0] fr;
            {op, phy, rg, d, resp, ta_ok} = VEC[i];
            rd = (op == 2'b10);
            arm_phy(rd, resp, ta_ok);
            fr = frame_exp(op, phy, rg, d);
            run_txn(word_of(1'b1, op, phy, rg, d), cyc);
            // R7: exact busy length
            check(cyc == TXN_CYCLES, "R7 busy length", 64'(cyc), 64'(TXN_CYCLES));
            check(rise_n == 64, "R1 one frame of MDC rises", 64'(rise_n), 64'd64);
            exp_fail = rd && !ta_ok;
            exp_d = rd ? (ta_ok ? resp : 16'hFFFF) : d;
            if (rd) begin
                // R3: header bits up to turnaround
                check(seen[63:18] == fr[63:18], "R3 read header", {18'h0, seen[63:18]}, {18'h0, fr[63:18]});
                check(!oe_clash, "R4 bus released", {63'h0, oe_clash}, 64'h0);
                check(cmd_rdata[15:0] == exp_d, "R4 read data", {48'h0, cmd_rdata[15:0]}, {48'h0, exp_d});
            end else begin
                check(seen == fr, "R3 write frame", seen, fr);
            end
            // R5 / R1: status after completion
            check(cmd_rdata == {2'b00, 1'b0, exp_fail, op, phy, rg, exp_d}, "R5 status word",
                  {32'h0, cmd_rdata}, {32'h0, 2'b00, 1'b0, exp_fail, op, phy, rg, exp_d});
        end

        // R2: write while busy is ignored
        arm_phy(1'b0, 16'h0, 1'b1);
        write_word(word_of(1'b1, 2'b01, 5'd3, 5'd4, 16'h0A0A));
        repeat (20) @(negedge clk);
        write_word(word_of(1'b1, 2'b10, 5'd9, 5'd9, 16'h1111));
        check(cmd_rdata[29:0] == {1'b1, 1'b0, 2'b01, 5'd3, 5'd4, 16'h0A0A}, "R2 fields kept",
              {34'h0, cmd_rdata[29:0]}, {34'h0, 1'b1, 1'b0, 2'b01, 5'd3, 5'd4, 16'h0A0A});
        cyc = 0;
        while (cmd_rdata[29] && cyc < 4000) begin @(negedge clk); cyc++; end
        repeat (20) @(negedge clk);
        check(rise_n == 64, "R2 no second frame", 64'(rise_n), 64'd64);
        check(seen == frame_exp(2'b01, 5'd3, 5'd4, 16'h0A0A), "R2 frame unchanged",
              seen, frame_exp(2'b01, 5'd3, 5'd4, 16'h0A0A));

        // R8: idle write without start, after a failed read
        arm_phy(1'b1, 16'h0, 1'b0);
        run_txn(word_of(1'b1, 2'b10, 5'd2, 5'd2, 16'h0), cyc);
        check(cmd_rdata[28] == 1'b1, "R5 fail flag set", {63'h0, cmd_rdata[28]}, 64'h1);
        arm_phy(1'b0, 16'h0, 1'b1);
        write_word(word_of(1'b0, 2'b10, 5'd7, 5'd8, 16'h5555));
        repeat (20) @(negedge clk);
        check(cmd_rdata == {2'b00, 1'b0, 1'b1, 2'b10, 5'd7, 5'd8, 16'h5555}, "R8 stored, fail kept",
              {32'h0, cmd_rdata}, {32'h0, 2'b00, 1'b0, 1'b1, 2'b10, 5'd7, 5'd8, 16'h5555});
        check(rise_n == 0 && mdc == 1'b0, "R8 no frame", 64'(rise_n), 64'h0);

        // R6: MDC period while busy
        arm_phy(1'b0, 16'h0, 1'b1);
        write_word(word_of(1'b1, 2'b01, 5'd1, 5'd1, 16'h0));
        begin
            int hi = 0;
            for (int k = 0; k < 8 * HALF; k++) begin
                @(negedge clk);
                if (mdc) hi++;
            end
            check(hi == 4 * HALF, "R6 MDC duty", 64'(hi), 64'(4 * HALF));
        end

        // R9: reset during a frame
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(cmd_rdata == 32'h0 && mdc == 1'b0 && mdio_oe == 1'b0, "R9 mid-frame reset",
              {31'h0, mdc, cmd_rdata}, 64'h0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule